// File: doc/BRIEF.md
# Bit Scan and Zero-Count Unit

This execution unit answers four questions about one operand: where the lowest set bit is, where the highest set bit is, how many zero bits sit below the lowest set bit, and how many zero bits sit above the highest set bit. The operand is 16, 32 or 64 bits wide. Bits above the chosen width are ignored. The two scan operations return a bit index. The two count operations return a count from zero up to the operand width.

The two scan operations have a special case for an all-zero operand. They then hand back the destination value they were given, so the register file write leaves the destination unchanged, and they signal the zero operand through the zero flag. The count operations always produce a count. For them, the carry flag marks an all-zero operand and the zero flag marks a zero count.

The decode stage presents a strobe together with an operation code, a size code, the source operand and the current destination value. When the output register is built in, the result and both flags appear one clock later, together with a valid pulse.

Top module: `bsz_unit`

## Requirements
- R1: The size code selects the operand width: 01 selects 16 bits, 10 selects 32 bits and 11 selects 64 bits. Source bits at or above the selected width have no effect on the result or on either flag.
- R2: Operation code 00 (scan from bottom) returns the index of the least significant set bit of a nonzero operand.
- R3: Operation code 01 (scan from top) returns the index of the most significant set bit of a nonzero operand.
- R4: Operation code 10 (trailing count) returns the number of zero bits below the lowest set bit. An all-zero operand returns the width (16, 32 or 64).
- R5: Operation code 11 (leading count) returns the number of zero bits above the highest set bit, counted within the selected width. An all-zero operand returns the width.
- R6: For either scan operation with an all-zero operand, the result equals the supplied destination value bit for bit, and the zero flag is 1.
- R7: For either scan operation, the zero flag is 0 when the operand is nonzero, and the carry flag is always 0.
- R8: For either count operation, the carry flag is 1 exactly when the operand is zero, and the zero flag is 1 exactly when the count is zero. Result bits above bit 6 are 0.
- R9: The valid output rises one cycle after an input strobe and is low otherwise. The result and flags change only one cycle after a strobe and hold their values in all other cycles.
- R10: After reset, the valid output, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: the operands on this cycle are to be processed |
| opSel | input | 2 | Operation code (00 scan bottom, 01 scan top, 10 trailing count, 11 leading count) |
| sizeSel | input | 2 | Width code (01 = 16, 10 = 32, 11 = 64) |
| srcOp | input | 64 | Source operand |
| oldDst | input | 64 | Current destination value, returned by a scan of zero |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 64 | Value to write back |
| zeroFlag | output | 1 | Zero flag |
| carryFlag | output | 1 | Carry flag |

## Verification
The assertions assume that the size code is never 00 whenever the strobe is high. Under that assumption a zero operand to a count operation yields exactly 16, 32 or 64. The bench drives only the codes 01, 10 and 11, in both its fixed table and its random vectors. The assertions also treat the destination value as meaningful only in the cycle of the strobe. The bench changes it freely between strobes, which exercises the hold check.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  typedef enum logic [1:0] {
    OP_SCAN_LO = 2'b00,
    OP_SCAN_HI = 2'b01,
    OP_CNT_TZ  = 2'b10,
    OP_CNT_LZ  = 2'b11
  } opCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       isCount;   // count operation (vs. scan)
    logic       fromTop;   // work from the most significant end
    logic [2:0] widthHot;  // one-hot: [0]=narrow, [1]=mid, [2]=full
  } ctrlStrobe_t;

endpackage

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
  import bsz_pkg::*;
(
  input  logic [1:0]  opSel,
  input  logic [1:0]  sizeSel,
  output ctrlStrobe_t strobe
);

  opCode_t opCode;
  assign opCode = opCode_t'(opSel);

  always_comb begin
    strobe = '0;
    unique case (opCode)
      OP_SCAN_LO: begin strobe.isCount = 1'b0; strobe.fromTop = 1'b0; end
      OP_SCAN_HI: begin strobe.isCount = 1'b0; strobe.fromTop = 1'b1; end
      OP_CNT_TZ:  begin strobe.isCount = 1'b1; strobe.fromTop = 1'b0; end
      OP_CNT_LZ:  begin strobe.isCount = 1'b1; strobe.fromTop = 1'b1; end
      default:    begin strobe.isCount = 1'b0; strobe.fromTop = 1'b0; end
    endcase
    case (sizeSel)
      2'b01:   strobe.widthHot = 3'b001;
      2'b10:   strobe.widthHot = 3'b010;
      default: strobe.widthHot = 3'b100;
    endcase
  end

endmodule

// File: rtl/bsz_zcount.sv
// Counts zero bits from one end of a vector up to the first set bit.
module bsz_zcount #(
  parameter int W        = 64,
  parameter bit FROM_TOP = 1'b0,
  localparam int CW      = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);

  logic [W-1:0] ordered;

  generate
    if (FROM_TOP) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign ordered[i] = vec[W-1-i];
      end
    end else begin : g_fwd
      assign ordered = vec;
    end
  endgenerate

  always_comb begin
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (ordered[i]) count = CW'(i);
    end
  end

endmodule

// File: rtl/bsz_datapath.sv
module bsz_datapath
  import bsz_pkg::*;
#(
  parameter int DATA_W  = 64,
  localparam int NARROW_W = DATA_W / 4,
  localparam int MID_W    = DATA_W / 2,
  localparam int CW       = $clog2(DATA_W + 1),
  localparam int IW       = $clog2(DATA_W)
) (
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] oldDst,
  output logic [DATA_W-1:0] resNext,
  output logic              zeroNext,
  output logic              carryNext
);

  logic [DATA_W-1:0] lowMask;
  logic [CW-1:0]     widthVal;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] tzIn;
  logic              srcZero;
  logic [CW-1:0]     tzCnt;
  logic [CW-1:0]     lzFull;
  logic [CW-1:0]     lzAdj;
  logic [IW-1:0]     hiIdx;
  logic [CW-1:0]     cntSel;

  always_comb begin
    lowMask  = '0;
    widthVal = CW'(DATA_W);
    if (strobe.widthHot[0]) begin
      lowMask[NARROW_W-1:0] = '1;
      widthVal = CW'(NARROW_W);
    end else if (strobe.widthHot[1]) begin
      lowMask[MID_W-1:0] = '1;
      widthVal = CW'(MID_W);
    end else begin
      lowMask = '1;
    end
  end

  assign masked  = srcOp & lowMask;
  assign srcZero = (masked == '0);
  // Bits above the width forced to one: a zero operand then counts to the width
  assign tzIn    = masked | ~lowMask;

  bsz_zcount #(.W(DATA_W), .FROM_TOP(1'b0)) u_tz (.vec(tzIn),   .count(tzCnt));
  bsz_zcount #(.W(DATA_W), .FROM_TOP(1'b1)) u_lz (.vec(masked), .count(lzFull));

  assign lzAdj = lzFull - CW'(DATA_W) + widthVal;
  assign hiIdx = lzFull[IW-1:0] ^ {IW{1'b1}};

  always_comb begin
    cntSel    = strobe.fromTop ? lzAdj : tzCnt;
    zeroNext  = 1'b0;
    carryNext = 1'b0;
    resNext   = '0;
    if (strobe.isCount) begin
      resNext   = {{(DATA_W-CW){1'b0}}, cntSel};
      carryNext = srcZero;
      zeroNext  = (cntSel == '0);
    end else begin
      zeroNext = srcZero;
      if (srcZero)
        resNext = oldDst;
      else if (strobe.fromTop)
        resNext = {{(DATA_W-IW){1'b0}}, hiIdx};
      else
        resNext = {{(DATA_W-IW){1'b0}}, tzCnt[IW-1:0]};
    end
  end

endmodule

// File: rtl/bsz_unit.sv
module bsz_unit
  import bsz_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] oldDst,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              carryFlag
);

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] resNext;
  logic              zeroNext;
  logic              carryNext;

  bsz_ctrl u_ctrl (
    .opSel  (opSel),
    .sizeSel(sizeSel),
    .strobe (strobe)
  );

  bsz_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe   (strobe),
    .srcOp    (srcOp),
    .oldDst   (oldDst),
    .resNext  (resNext),
    .zeroNext (zeroNext),
    .carryNext(carryNext)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid  <= 1'b0;
          result    <= '0;
          zeroFlag  <= 1'b0;
          carryFlag <= 1'b0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            result    <= resNext;
            zeroFlag  <= zeroNext;
            carryFlag <= carryNext;
          end
        end
      end
    end else begin : g_comb
      assign outValid  = inValid;
      assign result    = resNext;
      assign zeroFlag  = zeroNext;
      assign carryFlag = carryNext;
    end
  endgenerate

endmodule

// File: rtl/bsz_unit_chk.sv
module bsz_unit_chk #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        opSel,
  input logic [1:0]        sizeSel,
  input logic [DATA_W-1:0] srcOp,
  input logic [DATA_W-1:0] oldDst,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              zeroFlag,
  input logic              carryFlag
);

  generate
    if (REG_OUT) begin : g_chk
      AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid); // R9
      AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid); // R9
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> ($stable(result) && $stable(zeroFlag) && $stable(carryFlag))); // R9
      AST_SCAN_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !opSel[1]) |=> !carryFlag); // R7
      AST_SCAN_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !opSel[1] && srcOp == '0) |=> (result == $past(oldDst) && zeroFlag)); // R6
      AST_COUNT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel[1] && srcOp == '0) |=>
          (carryFlag && !zeroFlag &&
           result == (($past(sizeSel) == 2'b01) ? DATA_W/4 :
                      ($past(sizeSel) == 2'b10) ? DATA_W/2 : DATA_W))); // R8
      AST_COUNT_NARROW: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel[1]) |=> (result[DATA_W-1:7] == '0 && result <= DATA_W)); // R8
      AST_COUNT_ZFLAG: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel[1]) |=> (zeroFlag == (result == '0))); // R8
    end
  endgenerate

  always_comb begin
    if (rstN && inValid)
      AST_SIZE_KNOWN: assert (sizeSel != 2'b00); // R1
  end

endmodule

bind bsz_unit bsz_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .sizeSel(sizeSel),
  .srcOp(srcOp), .oldDst(oldDst), .outValid(outValid), .result(result),
  .zeroFlag(zeroFlag), .carryFlag(carryFlag)
);

// File: tb/bsz_unit_test.sv
module bsz_unit_test;

  localparam int VW = 2 + 2 + 64 + 64 + 64 + 1 + 1;
  localparam int NV = 18;
  // {op, size, src, old, expected result, zero, carry}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b00, 2'b11, 64'h0000_0000_0000_0008, 64'h0, 64'd3, 1'b0, 1'b0},                    // R2
    {2'b00, 2'b01, 64'hFFFF_0000_0000_0000, 64'h1234, 64'h1234, 1'b1, 1'b0},              // R1 R6
    {2'b00, 2'b10, 64'h0001_0000_8000_0000, 64'h0, 64'd31, 1'b0, 1'b0},                   // R1 R2
    {2'b01, 2'b11, 64'h8000_0000_0000_0001, 64'h0, 64'd63, 1'b0, 1'b0},                   // R3
    {2'b01, 2'b01, 64'h0003_0000_0000_00F0, 64'h0, 64'd7, 1'b0, 1'b0},                    // R1 R3
    {2'b01, 2'b10, 64'h0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, 1'b1, 1'b0},  // R6
    {2'b10, 2'b01, 64'h0, 64'h5, 64'd16, 1'b0, 1'b1},                                     // R4 R8
    {2'b10, 2'b10, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'd32, 1'b0, 1'b1},                   // R1 R4
    {2'b10, 2'b11, 64'h0, 64'h0, 64'd64, 1'b0, 1'b1},                                     // R4
    {2'b10, 2'b11, 64'h1, 64'h0, 64'd0, 1'b1, 1'b0},                                      // R8
    {2'b10, 2'b10, 64'h0000_0000_0004_0000, 64'h0, 64'd18, 1'b0, 1'b0},                   // R4
    {2'b11, 2'b01, 64'h1, 64'h0, 64'd15, 1'b0, 1'b0},                                     // R5
    {2'b11, 2'b01, 64'h8000, 64'h0, 64'd0, 1'b1, 1'b0},                                   // R5 R8
    {2'b11, 2'b10, 64'h0000_0001_0000_0000, 64'h0, 64'd32, 1'b0, 1'b1},                   // R1 R5
    {2'b11, 2'b11, 64'h0000_0000_0001_0000, 64'h0, 64'd47, 1'b0, 1'b0},                   // R5
    {2'b11, 2'b11, 64'h0, 64'h0, 64'd64, 1'b0, 1'b1},                                     // R5
    {2'b00, 2'b11, 64'h8000_0000_0000_0000, 64'h0, 64'd63, 1'b0, 1'b0},                   // R2
    {2'b11, 2'b10, 64'h0000_0000_00F0_0000, 64'h0, 64'd8, 1'b0, 1'b0}                     // R5
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [1:0]  sizeSel = 2'b11;
  logic [63:0] srcOp = '0;
  logic [63:0] oldDst = '0;
  logic        outValid;
  logic [63:0] result;
  logic        zeroFlag;
  logic        carryFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bsz_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .sizeSel(sizeSel),
    .srcOp(srcOp), .oldDst(oldDst), .outValid(outValid), .result(result),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent reference built from the requirement text
  task automatic refModel(input logic [1:0] op, input logic [1:0] sz,
                          input logic [63:0] src, input logic [63:0] old,
                          output logic [63:0] res, output logic z, output logic c);
    int w;
    int lo;
    int hi;
    w  = (sz == 2'b01) ? 16 : (sz == 2'b10) ? 32 : 64;
    lo = -1;
    hi = -1;
    for (int i = 0; i < w; i++) begin
      if (src[i]) begin
        if (lo < 0) lo = i;
        hi = i;
      end
    end
    c = 1'b0;
    case (op)
      2'b00: begin res = (lo < 0) ? old : 64'(lo); z = (lo < 0); end
      2'b01: begin res = (hi < 0) ? old : 64'(hi); z = (hi < 0); end
      2'b10: begin res = (lo < 0) ? 64'(w) : 64'(lo); c = (lo < 0); z = (res == 0); end
      default: begin res = (hi < 0) ? 64'(w) : 64'(w - 1 - hi); c = (hi < 0); z = (res == 0); end
    endcase
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] sz,
                       input logic [63:0] src, input logic [63:0] old);
    @(negedge clk);
    inValid = 1'b1;
    opSel   = op;
    sizeSel = sz;
    srcOp   = src;
    oldDst  = old;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    logic [63:0] eRes;
    logic        eZ;
    logic        eC;
    logic [63:0] heldRes;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 outValid", 64'(outValid), 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 flags", {62'd0, zeroFlag, carryFlag}, 64'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      issue(v[197:196], v[195:194], v[193:130], v[129:66]);
      check("R9 outValid after strobe", 64'(outValid), 64'd1);
      check("R1-table result (R2 R3 R4 R5 R6)", result, v[65:2]);
      check("R7 R8 zero flag", 64'(zeroFlag), 64'(v[1]));
      check("R7 R8 carry flag", 64'(carryFlag), 64'(v[0]));
    end

    // R9: no strobe -> valid low, outputs held though inputs move
    heldRes = result;
    @(negedge clk);
    opSel = 2'b11; srcOp = 64'h1; oldDst = 64'hFFFF;
    @(negedge clk);
    check("R9 outValid idle", 64'(outValid), 64'd0);
    check("R9 result held", result, heldRes);

    // R9: back-to-back strobes
    @(negedge clk);
    inValid = 1'b1; opSel = 2'b10; sizeSel = 2'b11; srcOp = 64'h100;
    @(negedge clk);
    check("R4 first of pair", result, 64'd8);
    check("R9 valid first of pair", 64'(outValid), 64'd1);
    opSel = 2'b01; srcOp = 64'h100;
    @(negedge clk);
    inValid = 1'b0;
    check("R3 second of pair", result, 64'd8);
    check("R9 valid second of pair", 64'(outValid), 64'd1);

    // R6: scan of zero with all-ones destination at 16-bit width
    issue(2'b00, 2'b01, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 full old value", result, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 zero flag", 64'(zeroFlag), 64'd1);

    // Random vectors against the reference
    for (int k = 0; k < 400; k++) begin
      logic [1:0]  op;
      logic [1:0]  sz;
      logic [63:0] src;
      logic [63:0] old;
      op  = 2'($urandom);
      sz  = 2'(1 + ($urandom % 3));
      src = {$urandom, $urandom};
      if (k % 2 == 0) src = src >> ($urandom % 64);
      if (k % 7 == 0) src = src << ($urandom % 64);
      if (k % 13 == 0) src = '0;
      old = {$urandom, $urandom};
      refModel(op, sz, src, old, eRes, eZ, eC);
      issue(op, sz, src, old);
      check("R1 R2 R3 R4 R5 R6 random result", result, eRes);
      check("R7 R8 random flags", {62'd0, zeroFlag, carryFlag}, {62'd0, eZ, eC});
    end

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule